// File: doc/BRIEF.md
# Receive Character Queue with Per-Entry Error Tags

This block is the receive side buffer of a serial port. A deserialiser hands it one character at a time, together with three error flags: parity, framing and break. The block keeps each character and its flags side by side and shows the oldest unread character to the reader. It also presents the line status that belongs to that character.

Error outputs follow the character at the head of the queue. Once set, they hold until software reads the line status, even if the faulty character has already been taken out. A separate summary output reports an error tag on any character still queued. A sticky overrun flag records every character that arrives with no room and is discarded.

With the queue mode deselected, the block shrinks to a single holding register with the same status behaviour.

Top module: `rx_err_fifo`

## Requirements
- R1: `char_avail` is 1 exactly when at least one unread character is held.
- R2: In queue mode (`fifo_en`=1) up to DEPTH (default 64) characters are held with their flags and read back in arrival order. `rd_char` shows the oldest one, and each `data_rd` pulse removes it.
- R3: `par_err`, `frm_err` and `brk_seen` are 1 in the cycle after a character with that flag reaches the head of the queue.
- R4: Every error output that has been set stays at 1 until a `status_rd` pulse, even after its character is removed. A `status_rd` clears it unless the current head character carries that flag.
- R5: `queue_err` is 1 while any held character has an error flag. After those characters are removed it stays at 1 until a `status_rd` pulse, after which it is recomputed from the characters still held.
- R6: With `fifo_en`=0 the block holds one character only. A second character that arrives before the first is read is an overrun, and the error outputs show the flags of the held character.
- R7: A character pushed while the store is full, with no read in the same cycle, is discarded and sets `ovr_err`. `ovr_err` holds until `status_rd`. A discard in the same cycle as `status_rd` leaves it set.
- R8: A push and a read in the same cycle on a full store both take effect, and no overrun is flagged.
- R9: A `data_rd` pulse with nothing held changes nothing. `rd_char` keeps the last character removed, which is 0 after reset.
- R10: After synchronous reset every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_en | input | 1 | 1 = queue mode, 0 = single holding register |
| rx_push | input | 1 | Strobe: a received character is presented |
| rx_char | input | 8 | Received character |
| rx_par_err | input | 1 | Parity error flag of the character |
| rx_frm_err | input | 1 | Framing error flag of the character |
| rx_brk | input | 1 | Break flag of the character |
| data_rd | input | 1 | Strobe: data register read (removes head) |
| status_rd | input | 1 | Strobe: line status read (clears sticky bits) |
| rd_char | output | 8 | Head character, or last removed character when empty |
| char_avail | output | 1 | Data ready |
| par_err | output | 1 | Sticky parity error status |
| frm_err | output | 1 | Sticky framing error status |
| brk_seen | output | 1 | Sticky break status |
| ovr_err | output | 1 | Sticky overrun status |
| queue_err | output | 1 | Error on some queued character, sticky until status read |

## Verification
Two pairs of functions can meet in the same cycle, and the bench drives both.

The first pair is a push and a read on a full queue. The bench fills all entries and pulses both strobes together. It then expects no overrun, and the drain order must show the new character last.

The second pair is a status read and a new error event. The bench pulses `status_rd` together with a discarded push, and together with a push of a flagged character onto an empty store. The expected outputs afterwards are `ovr_err` still set in the first case and the new flag visible in the second.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
    localparam int DATA_W = 8;
    localparam int FLAG_W = 3;

    typedef struct packed {
        logic brk;
        logic frm;
        logic par;
    } rx_flags_t;

    typedef struct packed {
        rx_flags_t           flags;
        logic [DATA_W-1:0]   data;
    } rx_entry_t;

    function automatic logic flags_bad(input rx_flags_t f);
        return f.brk | f.frm | f.par;
    endfunction
endpackage

// File: rtl/rxq_store.sv
module rxq_store
    import rxq_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fifo_en,
    input  logic              push_req,
    input  rx_entry_t         wr_entry,
    input  logic              pop_req,
    output logic              accept,
    output logic              drop,
    output logic              pop_ok,
    output logic              head_valid,
    output rx_entry_t         head,
    output logic [DATA_W-1:0] last_data
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    rx_entry_t        mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] cap;
    logic             full;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_comb begin
        cap        = fifo_en ? CNT_W'(DEPTH) : CNT_W'(1);
        full       = (count >= cap);
        head_valid = (count != '0);
        pop_ok     = pop_req & head_valid;
        accept     = push_req & (~full | pop_ok);
        drop       = push_req & ~accept;
        head       = mem[rd_ptr];
    end

    always_ff @(posedge clk) begin
        if (accept) mem[wr_ptr] <= wr_entry;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr    <= '0;
            rd_ptr    <= '0;
            count     <= '0;
            last_data <= '0;
        end else begin
            if (accept) wr_ptr <= ptr_inc(wr_ptr);
            if (pop_ok) begin
                rd_ptr    <= ptr_inc(rd_ptr);
                last_data <= head.data;
            end
            case ({accept, pop_ok})
                2'b10:   count <= count + CNT_W'(1);
                2'b01:   count <= count - CNT_W'(1);
                default: count <= count;
            endcase
        end
    end

    // R2: occupancy never exceeds the configured depth
    assert_count_bound_R2: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH));

    // R8: push with simultaneous pop keeps occupancy constant
    assert_swap_keeps_count_R8: assert property (@(posedge clk) disable iff (rst)
        (accept && pop_ok) |=> $stable(count));
endmodule

// File: rtl/rxq_flag_hold.sv
module rxq_flag_hold
    import rxq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              head_valid,
    input  logic [FLAG_W-1:0] head_flags,
    input  logic              status_rd,
    input  logic              drop,
    output logic [FLAG_W-1:0] err_out,
    output logic              ovr_out
);
    logic [FLAG_W-1:0] held_q;
    logic [FLAG_W-1:0] live;

    always_comb begin
        live    = head_valid ? head_flags : '0;
        err_out = held_q | live;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q  <= '0;
            ovr_out <= 1'b0;
        end else begin
            held_q  <= status_rd ? '0 : (held_q | live);
            ovr_out <= drop | (ovr_out & ~status_rd);
        end
    end

    // R4: no error bit falls without a status read
    assert_err_sticky_R4: assert property (@(posedge clk) disable iff (rst)
        !status_rd |=> ((err_out & $past(err_out)) == $past(err_out)));

    // R7: a discarded push always raises overrun
    assert_overrun_set_R7: assert property (@(posedge clk) disable iff (rst)
        drop |=> ovr_out);

    // R7: overrun holds until a status read
    assert_overrun_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (ovr_out && !status_rd) |=> ovr_out);
endmodule

// File: rtl/rxq_any_track.sv
module rxq_any_track #(
    parameter int DEPTH = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic accept,
    input  logic wr_bad,
    input  logic pop_ok,
    input  logic head_bad,
    input  logic status_rd,
    output logic err_any
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [CNT_W-1:0] bad_cnt;
    logic             any_q;
    logic             inc, dec;

    always_comb begin
        inc     = accept & wr_bad;
        dec     = pop_ok & head_bad;
        err_any = any_q | (bad_cnt != '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bad_cnt <= '0;
            any_q   <= 1'b0;
        end else begin
            case ({inc, dec})
                2'b10:   bad_cnt <= bad_cnt + CNT_W'(1);
                2'b01:   bad_cnt <= bad_cnt - CNT_W'(1);
                default: bad_cnt <= bad_cnt;
            endcase
            any_q <= status_rd ? 1'b0 : (any_q | (bad_cnt != '0));
        end
    end

    // R5: summary bit holds until a status read
    assert_any_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (err_any && !status_rd) |=> err_any);

    // R5: tagged-entry count stays within depth
    assert_bad_bound_R5: assert property (@(posedge clk) disable iff (rst)
        bad_cnt <= CNT_W'(DEPTH));
endmodule

// File: rtl/rx_err_fifo.sv
module rx_err_fifo
    import rxq_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fifo_en,
    input  logic              rx_push,
    input  logic [DATA_W-1:0] rx_char,
    input  logic              rx_par_err,
    input  logic              rx_frm_err,
    input  logic              rx_brk,
    input  logic              data_rd,
    input  logic              status_rd,
    output logic [DATA_W-1:0] rd_char,
    output logic              char_avail,
    output logic              par_err,
    output logic              frm_err,
    output logic              brk_seen,
    output logic              ovr_err,
    output logic              queue_err
);
    rx_entry_t         wr_entry, head;
    logic              accept, drop, pop_ok, head_valid;
    logic [DATA_W-1:0] last_data;
    logic [FLAG_W-1:0] err_vec;
    rx_flags_t         err_flags;

    always_comb begin
        wr_entry.data      = rx_char;
        wr_entry.flags.par = rx_par_err;
        wr_entry.flags.frm = rx_frm_err;
        wr_entry.flags.brk = rx_brk;
    end

    rxq_store #(.DEPTH(DEPTH)) u_store (
        .clk        (clk),
        .rst        (rst),
        .fifo_en    (fifo_en),
        .push_req   (rx_push),
        .wr_entry   (wr_entry),
        .pop_req    (data_rd),
        .accept     (accept),
        .drop       (drop),
        .pop_ok     (pop_ok),
        .head_valid (head_valid),
        .head       (head),
        .last_data  (last_data)
    );

    rxq_flag_hold u_hold (
        .clk        (clk),
        .rst        (rst),
        .head_valid (head_valid),
        .head_flags (head.flags),
        .status_rd  (status_rd),
        .drop       (drop),
        .err_out    (err_vec),
        .ovr_out    (ovr_err)
    );

    rxq_any_track #(.DEPTH(DEPTH)) u_any (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .wr_bad    (flags_bad(wr_entry.flags)),
        .pop_ok    (pop_ok),
        .head_bad  (flags_bad(head.flags)),
        .status_rd (status_rd),
        .err_any   (queue_err)
    );

    always_comb begin
        err_flags  = rx_flags_t'(err_vec);
        par_err    = err_flags.par;
        frm_err    = err_flags.frm;
        brk_seen   = err_flags.brk;
        char_avail = head_valid;
        rd_char    = head_valid ? head.data : last_data;
    end

    // R1: a push onto an empty store always makes data ready
    assert_ready_after_push_R1: assert property (@(posedge clk) disable iff (rst)
        (rx_push && !char_avail) |=> char_avail);

    // R9: reading an empty store changes nothing visible
    assert_empty_read_R9: assert property (@(posedge clk) disable iff (rst)
        (data_rd && !char_avail && !rx_push) |=> ($stable(rd_char) && !char_avail));

    // R5: a flagged head character implies the summary bit
    assert_head_bad_any_R5: assert property (@(posedge clk) disable iff (rst)
        (char_avail && (par_err || frm_err || brk_seen) && !status_rd) |=> (queue_err || !char_avail || $past(!flags_bad(head.flags))));
endmodule

// File: tb/test_rx_err_fifo.sv
module test_rx_err_fifo;
    logic       clk = 1'b0;
    logic       rst;
    logic       fifo_en;
    logic       rx_push;
    logic [7:0] rx_char;
    logic       rx_par_err, rx_frm_err, rx_brk;
    logic       data_rd, status_rd;
    logic [7:0] rd_char;
    logic       char_avail, par_err, frm_err, brk_seen, ovr_err, queue_err;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    rx_err_fifo i_rx_err_fifo (
        .clk(clk), .rst(rst), .fifo_en(fifo_en),
        .rx_push(rx_push), .rx_char(rx_char),
        .rx_par_err(rx_par_err), .rx_frm_err(rx_frm_err), .rx_brk(rx_brk),
        .data_rd(data_rd), .status_rd(status_rd),
        .rd_char(rd_char), .char_avail(char_avail),
        .par_err(par_err), .frm_err(frm_err), .brk_seen(brk_seen),
        .ovr_err(ovr_err), .queue_err(queue_err)
    );

    // flags field: bit2 brk, bit1 frm, bit0 par
    typedef struct packed {
        logic       push;
        logic [7:0] data;
        logic [2:0] flags;
        logic       rdd;
        logic       rds;
        logic       e_rdy;
        logic [7:0] e_head;
        logic [2:0] e_err;
        logic       e_ovr;
        logic       e_any;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 8'h41, 3'b000, 1'b0, 1'b0, 1'b1, 8'h41, 3'b000, 1'b0, 1'b0},
        '{1'b1, 8'h42, 3'b001, 1'b0, 1'b0, 1'b1, 8'h41, 3'b000, 1'b0, 1'b1},
        '{1'b0, 8'h00, 3'b000, 1'b1, 1'b0, 1'b1, 8'h42, 3'b001, 1'b0, 1'b1},
        '{1'b0, 8'h00, 3'b000, 1'b1, 1'b0, 1'b0, 8'h42, 3'b001, 1'b0, 1'b1},
        '{1'b0, 8'h00, 3'b000, 1'b1, 1'b0, 1'b0, 8'h42, 3'b001, 1'b0, 1'b1},
        '{1'b0, 8'h00, 3'b000, 1'b0, 1'b1, 1'b0, 8'h42, 3'b000, 1'b0, 1'b0},
        '{1'b1, 8'h55, 3'b110, 1'b0, 1'b0, 1'b1, 8'h55, 3'b110, 1'b0, 1'b1},
        '{1'b0, 8'h00, 3'b000, 1'b0, 1'b1, 1'b1, 8'h55, 3'b110, 1'b0, 1'b1},
        '{1'b1, 8'h66, 3'b000, 1'b1, 1'b0, 1'b1, 8'h66, 3'b110, 1'b0, 1'b1},
        '{1'b0, 8'h00, 3'b000, 1'b1, 1'b1, 1'b0, 8'h66, 3'b000, 1'b0, 1'b0}
    };
    localparam string VTAG [NV] = '{"R1 R2", "R5", "R3", "R4 R5", "R9",
                                     "R4 R5", "R3", "R4", "R4 R8", "R4 R5"};

    function automatic logic [14:0] obs();
        return {char_avail, rd_char, brk_seen, frm_err, par_err, ovr_err, queue_err};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc(input logic p, input logic [7:0] d, input logic [2:0] f,
                       input logic rdd, input logic rds);
        rx_push = p; rx_char = d;
        {rx_brk, rx_frm_err, rx_par_err} = f;
        data_rd = rdd; status_rd = rds;
        @(posedge clk);
        @(negedge clk);
        rx_push = 1'b0; data_rd = 1'b0; status_rd = 1'b0;
        {rx_brk, rx_frm_err, rx_par_err} = 3'b000;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        finish_run();
    end

    initial begin
        rx_push = 0; rx_char = 0; rx_par_err = 0; rx_frm_err = 0; rx_brk = 0;
        data_rd = 0; status_rd = 0; fifo_en = 1'b1;
        @(negedge clk);
        do_reset();

        // R10: reset state
        check("R10 reset", 32'(obs()), 32'h0);

        // vector table walk
        for (int k = 0; k < NV; k++) begin
            cyc(VEC[k].push, VEC[k].data, VEC[k].flags, VEC[k].rdd, VEC[k].rds);
            check(VTAG[k], 32'(obs()),
                  32'({VEC[k].e_rdy, VEC[k].e_head, VEC[k].e_err, VEC[k].e_ovr, VEC[k].e_any}));
        end

        // R4 R3: status read together with a flagged push onto empty store
        cyc(1'b1, 8'h77, 3'b100, 1'b0, 1'b1);
        check("R4 R3 status+push", 32'({brk_seen, queue_err, rd_char}), 32'({1'b1, 1'b1, 8'h77}));
        cyc(1'b0, 8'h00, 3'b000, 1'b1, 1'b0);
        cyc(1'b0, 8'h00, 3'b000, 1'b0, 1'b1);
        check("R4 cleared", 32'(obs()), 32'({1'b0, 8'h77, 3'b000, 1'b0, 1'b0}));

        // R2: fill all 64 entries, last one with parity flag
        for (int i = 0; i < 64; i++)
            cyc(1'b1, 8'(i), (i == 63) ? 3'b001 : 3'b000, 1'b0, 1'b0);
        check("R2 full", 32'(obs()), 32'({1'b1, 8'h00, 3'b000, 1'b0, 1'b1}));

        // R7: push on full is discarded
        cyc(1'b1, 8'hEE, 3'b000, 1'b0, 1'b0);
        check("R7 overrun set", 32'({ovr_err, rd_char}), 32'({1'b1, 8'h00}));
        // R7: discard with status read in the same cycle keeps overrun
        cyc(1'b1, 8'hEF, 3'b000, 1'b0, 1'b1);
        check("R7 set beats clear", 32'(ovr_err), 32'(1));
        cyc(1'b0, 8'h00, 3'b000, 1'b0, 1'b1);
        check("R7 overrun clear", 32'(ovr_err), 32'(0));

        // R8: push and read together on full store
        cyc(1'b1, 8'hAB, 3'b000, 1'b1, 1'b0);
        check("R8 swap", 32'({ovr_err, char_avail, rd_char}), 32'({1'b0, 1'b1, 8'h01}));

        // R2: drain in arrival order
        for (int k = 1; k <= 64; k++) begin
            check("R2 order", 32'(rd_char), (k == 64) ? 32'hAB : 32'(k));
            if (k == 63) check("R3 head flag", 32'(par_err), 32'(1));
            cyc(1'b0, 8'h00, 3'b000, 1'b1, 1'b0);
        end
        check("R4 R5 after drain", 32'(obs()), 32'({1'b0, 8'hAB, 3'b001, 1'b0, 1'b1}));
        cyc(1'b0, 8'h00, 3'b000, 1'b0, 1'b1);
        check("R5 recomputed", 32'(obs()), 32'({1'b0, 8'hAB, 3'b000, 1'b0, 1'b0}));

        // R6: holding-register mode
        fifo_en = 1'b0;
        cyc(1'b1, 8'h11, 3'b010, 1'b0, 1'b0);
        check("R6 held", 32'({char_avail, rd_char, frm_err}), 32'({1'b1, 8'h11, 1'b1}));
        cyc(1'b1, 8'h22, 3'b000, 1'b0, 1'b0);
        check("R6 second overruns", 32'({ovr_err, rd_char}), 32'({1'b1, 8'h11}));
        cyc(1'b0, 8'h00, 3'b000, 1'b1, 1'b0);
        check("R6 R1 read", 32'({char_avail, rd_char}), 32'({1'b0, 8'h11}));
        cyc(1'b1, 8'h22, 3'b000, 1'b0, 1'b0);
        check("R6 R4 next", 32'({char_avail, rd_char, frm_err}), 32'({1'b1, 8'h22, 1'b1}));
        cyc(1'b0, 8'h00, 3'b000, 1'b0, 1'b1);
        check("R6 status", 32'({frm_err, ovr_err}), 32'(0));

        // R10 R9: reset mid-content, then read while empty
        fifo_en = 1'b1;
        do_reset();
        check("R10 reset with data", 32'(obs()), 32'h0);
        cyc(1'b0, 8'h00, 3'b000, 1'b1, 1'b0);
        check("R9 empty read", 32'(obs()), 32'h0);
        cyc(1'b1, 8'h3C, 3'b000, 1'b0, 1'b0);
        check("R9 R1 push after", 32'({char_avail, rd_char}), 32'({1'b1, 8'h3C}));

        finish_run();
    end
endmodule